// File: doc/BRIEF.md
# Pipelined Data Tenure Scheduler

This block sits in a bus master and keeps track of the data phases that are still owed once their address phases have finished. Address phases can overlap, so up to two data phases may wait for the data bus at the same time. Each waiting phase is stored in a small queue as three attributes: read or write, burst or single, and whether a single transfer is a full doubleword.

When the data bus arbiter gives a grant that counts, the scheduler picks one waiting tenure and raises its own busy output. It then counts beat acknowledges until the transfer is complete and removes the tenure from the queue. Tenures normally run in the order they were queued. A write-only hint that is sampled together with the grant lets the oldest queued write go ahead of an older read.

One parameter selects a 64-bit or a 32-bit data path. The data path width sets how many beats each kind of transfer takes.

Top module: `data_tenure_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done`, `cur_write`, `cur_burst`, `ovf_err` are 0 and `beat_idx` is 0.
- R2: The queue holds at most two tenures. A push while two are held is dropped: the queue contents and the order of later transfers do not change, and `ovf_err` is 1 for exactly the cycle after the push.
- R3: With `wr_only` low at the grant, the oldest queued tenure is the one that runs.
- R4: With `wr_only` high at a qualified grant, the oldest queued write runs, even when an older read is queued. The skipped read stays the oldest entry and runs at the next grant.
- R5: With `wr_only` high at a qualified grant and no write queued, the oldest read still runs and `busy` rises.
- R6: A grant is qualified when `grant` is 1, `ext_busy` is 0, `busy` is 0 and at least one tenure is queued. `busy` rises on the clock edge that samples a qualified grant. In any other case `busy` does not rise.
- R7: On the 64-bit path (`WIDE_PATH`=1), a burst takes 4 beats and any single transfer takes 1 beat.
- R8: On the 32-bit path (`WIDE_PATH`=0), a burst takes 8 beats, a doubleword single takes 2 beats and any other single takes 1 beat.
- R9: `beat_idx` starts at 0 at the grant and advances by one on each non-final `beat_ack`. It holds at the last index after the final ack. A `beat_ack` while no beat is outstanding is ignored.
- R10: After the final `beat_ack`, `busy` stays 1 for one more cycle with `done` = 1. The tenure is then removed and `busy` falls.
- R11: While `busy` is 1, `cur_write` and `cur_burst` show the running tenure. While `busy` is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| enq_valid | input | 1 | Push one tenure into the queue |
| enq_write | input | 1 | Pushed tenure is a write (1) or a read (0) |
| enq_burst | input | 1 | Pushed tenure is an aligned eight-word burst |
| enq_dword | input | 1 | Pushed single transfer is a full doubleword |
| grant | input | 1 | Data bus grant from the arbiter |
| ext_busy | input | 1 | Another master holds the data bus |
| wr_only | input | 1 | Write-only hint, sampled with the grant |
| beat_ack | input | 1 | Acknowledge for the current beat |
| busy | output | 1 | This master owns the data bus |
| cur_write | output | 1 | The running tenure is a write |
| cur_burst | output | 1 | The running tenure is a burst |
| beat_idx | output | BW | Index of the current beat (BW = 2 wide, 3 narrow) |
| done | output | 1 | Final beat acknowledged, tenure retiring |
| ovf_err | output | 1 | The previous cycle's push was dropped because the queue was full |

## Verification
The assertions assume that all inputs are known after reset and that `rst_n` is released away from a clock edge. They place no limit on when `beat_ack`, `grant`, `ext_busy` or `wr_only` arrive, because the block has to ignore or qualify each of them itself. The random stimulus therefore drives every control input independently on every cycle, including acks while idle and grants while the bus is taken by this master or another one. The stimulus pushes often enough to hit a full queue regularly, so drops and promotions occur during the run and not only in the directed cases.

// File: rtl/dts_pkg.sv
package dts_pkg;

  typedef struct packed {
    logic wr;
    logic burst;
    logic dword;
  } tenure_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_XFER = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

endpackage

// File: rtl/dts_queue.sv
module dts_queue
  import dts_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  tenure_t                      push_ent,
  input  logic                         pick,
  input  logic                         wr_only,
  input  logic                         retire,
  output tenure_t                      active_ent,
  output logic                         have_work,
  output logic                         ovf
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tenure_t          slot_q [DEPTH];
  tenure_t          slot_n [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_n, cnt_mid;
  logic [IW-1:0]    sel_q, pick_idx, fw_idx;
  logic             fw_found;
  logic             ovf_q, ovf_n;
  logic             slot_en, push_ok;

  // oldest queued write
  always_comb begin
    fw_found = 1'b0;
    fw_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((CW'(i) < cnt_q) && slot_q[i].wr) begin
        fw_found = 1'b1;
        fw_idx   = IW'(i);
      end
    end
  end

  assign pick_idx = (wr_only && fw_found) ? fw_idx : '0;

  always_comb begin
    slot_n  = slot_q;
    cnt_mid = cnt_q;
    if (retire) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IW'(i) >= sel_q) slot_n[i] = slot_q[i+1];
      end
      cnt_mid = cnt_q - CW'(1);
    end
    ovf_n   = push && (cnt_q == CW'(DEPTH));
    push_ok = push && !ovf_n;
    cnt_n   = cnt_mid;
    if (push_ok) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == cnt_mid) slot_n[i] = push_ent;
      end
      cnt_n = cnt_mid + CW'(1);
    end
    slot_en = retire || push_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
      if (pick) sel_q <= pick_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (slot_en) slot_q <= slot_n;
  end

  assign active_ent = slot_q[sel_q];
  assign have_work  = (cnt_q != '0);
  assign ovf        = ovf_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(push && (cnt_q == CW'(DEPTH))));
  assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (cnt_q == CW'(DEPTH)) && !retire) |=> (cnt_q == CW'(DEPTH)));
  assert_inorder_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && !wr_only) |=> (sel_q == '0));
  assert_promote_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && wr_only && fw_found) |=> active_ent.wr);
  assert_retire_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (cnt_q != '0));

endmodule

// File: rtl/dts_beat_ctrl.sv
module dts_beat_ctrl
  import dts_pkg::*;
#(
  parameter bit WIDE_PATH = 1'b1,
  parameter int BW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic          ext_busy,
  input  logic          have_work,
  input  logic          beat_ack,
  input  tenure_t       ent,
  output logic          pick,
  output logic          retire,
  output logic          busy,
  output logic          done,
  output logic [BW-1:0] beat_idx
);

  localparam int BURST_BEATS = WIDE_PATH ? 4 : 8;
  localparam int DWORD_BEATS = WIDE_PATH ? 1 : 2;

  phase_e        phase_q, phase_n;
  logic [BW-1:0] beat_q, beat_n, last_beat;
  logic          phase_en, beat_en;

  always_comb begin
    if (ent.burst)      last_beat = BW'(BURST_BEATS - 1);
    else if (ent.dword) last_beat = BW'(DWORD_BEATS - 1);
    else                last_beat = '0;
  end

  assign pick   = (phase_q == PH_IDLE) && grant && !ext_busy && have_work;
  assign retire = (phase_q == PH_TAIL);

  always_comb begin
    phase_n = phase_q;
    beat_n  = beat_q;
    unique case (phase_q)
      PH_IDLE: if (pick) begin
        phase_n = PH_XFER;
        beat_n  = '0;
      end
      PH_XFER: if (beat_ack) begin
        if (beat_q == last_beat) phase_n = PH_TAIL;
        else                     beat_n  = beat_q + BW'(1);
      end
      PH_TAIL: begin
        phase_n = PH_IDLE;
        beat_n  = '0;
      end
      default: begin
        phase_n = PH_IDLE;
        beat_n  = '0;
      end
    endcase
    phase_en = (phase_n != phase_q);
    beat_en  = (beat_n != beat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      beat_q  <= '0;
    end else begin
      if (phase_en) phase_q <= phase_n;
      if (beat_en)  beat_q  <= beat_n;
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign done     = (phase_q == PH_TAIL);
  assign beat_idx = beat_q;

  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(grant && !ext_busy && have_work));
  assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_done_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_beat_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (beat_q <= last_beat));
  assert_idle_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (beat_q == '0));

endmodule

// File: rtl/data_tenure_sched.sv
module data_tenure_sched
  import dts_pkg::*;
#(
  parameter bit WIDE_PATH = 1'b1,
  parameter int QDEPTH    = 2,
  parameter int BW        = WIDE_PATH ? 2 : 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic          enq_write,
  input  logic          enq_burst,
  input  logic          enq_dword,
  input  logic          grant,
  input  logic          ext_busy,
  input  logic          wr_only,
  input  logic          beat_ack,
  output logic          busy,
  output logic          cur_write,
  output logic          cur_burst,
  output logic [BW-1:0] beat_idx,
  output logic          done,
  output logic          ovf_err
);

  tenure_t push_ent, active_ent;
  logic    pick, retire, have_work;

  assign push_ent = '{wr: enq_write, burst: enq_burst, dword: enq_dword};

  dts_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (enq_valid),
    .push_ent   (push_ent),
    .pick       (pick),
    .wr_only    (wr_only),
    .retire     (retire),
    .active_ent (active_ent),
    .have_work  (have_work),
    .ovf        (ovf_err)
  );

  dts_beat_ctrl #(.WIDE_PATH(WIDE_PATH), .BW(BW)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .ext_busy  (ext_busy),
    .have_work (have_work),
    .beat_ack  (beat_ack),
    .ent       (active_ent),
    .pick      (pick),
    .retire    (retire),
    .busy      (busy),
    .done      (done),
    .beat_idx  (beat_idx)
  );

  assign cur_write = busy && active_ent.wr;
  assign cur_burst = busy && active_ent.burst;

  assert_idle_type_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cur_write && !cur_burst));
  assert_type_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cur_write) && $stable(cur_burst)));

endmodule

// File: tb/data_tenure_sched_test.sv
module data_tenure_sched_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 0, enq_write = 0, enq_burst = 0, enq_dword = 0;
  logic grant = 0, ext_busy = 0, wr_only = 0, beat_ack = 0;

  logic       busy_w, cw_w, cb_w, done_w, ovf_w;
  logic [1:0] bi_w;
  logic       busy_n, cw_n, cb_n, done_n, ovf_n;
  logic [2:0] bi_n;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  data_tenure_sched #(.WIDE_PATH(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_write(enq_write),
    .enq_burst(enq_burst), .enq_dword(enq_dword), .grant(grant), .ext_busy(ext_busy),
    .wr_only(wr_only), .beat_ack(beat_ack), .busy(busy_w), .cur_write(cw_w),
    .cur_burst(cb_w), .beat_idx(bi_w), .done(done_w), .ovf_err(ovf_w));

  data_tenure_sched #(.WIDE_PATH(1'b0)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_write(enq_write),
    .enq_burst(enq_burst), .enq_dword(enq_dword), .grant(grant), .ext_busy(ext_busy),
    .wr_only(wr_only), .beat_ack(beat_ack), .busy(busy_n), .cur_write(cw_n),
    .cur_burst(cb_n), .beat_idx(bi_n), .done(done_n), .ovf_err(ovf_n));

  // reference model, index 0 = wide path, 1 = narrow path
  int       m_st   [2];
  int       m_cnt  [2];
  int       m_sel  [2];
  int       m_beat [2];
  bit       m_ovf  [2];
  bit [2:0] m_q    [2][2];   // {wr, burst, dword}

  function automatic int beats_of(bit [2:0] e, int m);
    if (e[1]) return (m == 0) ? 4 : 8;
    if (e[0]) return (m == 0) ? 1 : 2;
    return 1;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      m_st[m] = 0; m_cnt[m] = 0; m_sel[m] = 0; m_beat[m] = 0; m_ovf[m] = 0;
    end
  endtask

  task automatic model_step();
    for (int m = 0; m < 2; m++) begin
      int cnt0 = m_cnt[m];
      m_ovf[m] = enq_valid && (cnt0 == 2);
      case (m_st[m])
        0: if (grant && !ext_busy && cnt0 > 0) begin
          if (wr_only && !m_q[m][0][2] && cnt0 == 2 && m_q[m][1][2]) m_sel[m] = 1;
          else m_sel[m] = 0;
          m_st[m] = 1; m_beat[m] = 0;
        end
        1: if (beat_ack) begin
          if (m_beat[m] == beats_of(m_q[m][m_sel[m]], m) - 1) m_st[m] = 2;
          else m_beat[m]++;
        end
        default: begin
          if (m_sel[m] == 0) m_q[m][0] = m_q[m][1];
          m_cnt[m]--; m_st[m] = 0; m_beat[m] = 0;
        end
      endcase
      if (enq_valid && cnt0 < 2) begin
        m_q[m][m_cnt[m]] = {enq_write, enq_burst, enq_dword};
        m_cnt[m]++;
      end
    end
  endtask

  task automatic compare_all();
    int eb, ew, ec;
    for (int m = 0; m < 2; m++) begin
      eb = (m_st[m] != 0);
      ew = eb ? m_q[m][m_sel[m]][2] : 0;
      ec = eb ? m_q[m][m_sel[m]][1] : 0;
      chk("R6", "busy", (m == 0) ? busy_w : busy_n, eb);
      chk("R10", "done", (m == 0) ? done_w : done_n, (m_st[m] == 2));
      chk((m == 0) ? "R7" : "R8", "beat_idx", (m == 0) ? int'(bi_w) : int'(bi_n), m_beat[m]);
      chk("R3", "cur_write", (m == 0) ? cw_w : cw_n, ew);
      chk("R11", "cur_burst", (m == 0) ? cb_w : cb_n, ec);
      chk("R2", "ovf_err", (m == 0) ? ovf_w : ovf_n, m_ovf[m]);
    end
  endtask

  task automatic tick(bit e, bit w, bit b, bit d, bit g, bit x, bit wo, bit a);
    enq_valid = e; enq_write = w; enq_burst = b; enq_dword = d;
    grant = g; ext_busy = x; wr_only = wo; beat_ack = a;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) tick(0, 0, 0, 0, 1, 0, 0, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7091));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy in reset", busy_w, 0);
    chk("R1", "ovf in reset", ovf_n, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy_n, 0);
    chk("R1", "done after reset", done_w, 0);
    chk("R1", "beat_idx after reset", int'(bi_n), 0);
    compare_all();

    // R9: ack while idle is ignored
    tick(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9", "idle ack beat_idx", int'(bi_w), 0);

    // R4: read then write burst queued, write-only promotes the write
    tick(1, 0, 0, 0, 0, 0, 0, 0);
    tick(1, 1, 1, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 0, 1, 0);
    chk("R4", "promoted write", cw_w, 1);
    chk("R4", "promoted burst narrow", cb_n, 1);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7", "wide burst at last beat", int'(bi_w), 3);
    tick(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10", "wide done after 4 acks", done_w, 1);
    chk("R10", "wide busy while done", busy_w, 1);
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8", "narrow done after 8 acks", done_n, 1);
    tick(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10", "busy falls after tail", busy_n, 0);
    tick(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4", "skipped read runs next", cw_w, 0);
    chk("R4", "skipped read busy", busy_w, 1);
    drain();

    // R5: two reads, write-only still takes the bus with the oldest read
    tick(1, 0, 0, 1, 0, 0, 0, 0);
    tick(1, 0, 1, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 0, 1, 0);
    chk("R5", "busy with no write", busy_w, 1);
    chk("R5", "oldest read runs", cb_w, 0);
    tick(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8", "narrow dword not last yet", done_n, 0);
    chk("R7", "wide dword single beat", done_w, 1);
    drain();

    // R6: ext_busy blocks the grant
    tick(1, 1, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 1, 0, 0);
    chk("R6", "grant while ext busy", busy_w, 0);

    // R2: overflow drops a third push
    tick(1, 0, 0, 0, 0, 0, 0, 0);
    tick(1, 1, 1, 0, 0, 0, 0, 0);
    chk("R2", "overflow flag", ovf_w, 1);
    tick(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", "overflow is one cycle", ovf_n, 0);
    tick(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R3", "oldest write first", cw_w, 1);
    drain();
    tick(0, 0, 0, 0, 1, 0, 1, 0);
    chk("R2", "dropped push left nothing", busy_w, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tick(($urandom % 100) < 35, $urandom % 2, ($urandom % 3) == 0, $urandom % 2,
           ($urandom % 100) < 40, ($urandom % 100) < 20, ($urandom % 100) < 35,
           ($urandom % 100) < 55);
    end
    finish_run();
  end

endmodule